// File: doc/BRIEF.md
# Indirect-Access Queue RAM Controller

This block is the working memory of a queued serial peripheral. It holds three segments of sixteen entries each. The first is a transmit segment of 16-bit words. The second is a receive segment of 16-bit words. The third is a command segment of 8-bit entries. The host never addresses the storage directly. It loads a 6-bit pointer through an address register, then moves words through a data register. Every data access, read or write, advances the pointer by one.

A separate peripheral-side port serves the serial engine. That engine fetches transmit words and command bytes by index. It deposits received words together with a bit count. The block clears the bits above that count to zero, stores the word, and records the entry index as the completed-queue pointer. Software uses that pointer to tell which receive entries hold fresh data.

A small host state machine has two states. ST_IDLE accepts accesses. ST_RD_WAIT inserts the single wait state that a data-register read needs. The transitions are:
- ST_IDLE goes to ST_RD_WAIT on a data-register read request.
- ST_RD_WAIT goes back to ST_IDLE unconditionally, and the pointer increments on that transition.
- Every other ST_IDLE cycle stays in ST_IDLE.

Top module: `qram_ctrl`

## Requirements
- R1: A host write with `h_sel_addr` high loads the low 6 bits of `h_wdata` into the address pointer. A host read with `h_sel_addr` high returns the pointer zero-extended to 16 bits, with `h_ready` high in the same cycle. When `h_sel_addr` is high, any data access requested in that cycle is ignored.
- R2: A data-register write (`h_sel_data` and `h_wr`, without `h_sel_addr`) stores `h_wdata` at the entry the pointer selects and increments the pointer by one. `h_ready` stays high during that cycle. When `h_wr` and `h_rd` are both high, the write wins.
- R3: A data-register read drives `h_ready` low in the request cycle (ST_IDLE to ST_RD_WAIT). In the following cycle, `h_ready` is high and `h_rdata` holds the entry. The pointer increments as the machine leaves ST_RD_WAIT. Only ST_IDLE accepts new accesses.
- R4: Pointer values 0x00-0x0F address the transmit words and 0x10-0x1F address the receive words. Transmit word n is presented on `p_tx_data` when `p_tx_idx` = n.
- R5: A host data read anywhere in the transmit segment returns 0x0000 and still increments the pointer.
- R6: Pointer values 0x20-0x2F address the command entries. A host write keeps only `h_wdata[7:0]`. A host read returns the entry zero-extended to 16 bits. Command entry n is presented on `p_cmd_data` when `p_cmd_idx` = n.
- R7: Pointer values 0x30-0x3F reach no storage. Writes there change no entry, and reads return 0x0000. The pointer still increments and wraps from 0x3F to 0x00.
- R8: A peripheral write (`p_rx_we`) stores `p_rx_data` into receive entry `p_rx_idx`, with every bit at or above the effective count cleared. The effective count is `p_rx_bits` clamped to the range 8..16.
- R9: A peripheral write sets `cptr` to `p_rx_idx`, and the new value is visible from the next cycle.
- R10: Reset (`rst_n` low, asynchronous) clears the pointer, `cptr` and every entry, and leaves the machine in ST_IDLE with `h_ready` high.
- R11: If a host write and a peripheral write hit the same receive entry in one cycle, the peripheral value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel_addr | input | 1 | Host selects the address register |
| h_sel_data | input | 1 | Host selects the data register |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data |
| h_ready | output | 1 | Access complete; low during the read wait state |
| p_tx_idx | input | 4 | Peripheral transmit entry index |
| p_tx_data | output | 16 | Transmit word at `p_tx_idx` |
| p_cmd_idx | input | 4 | Peripheral command entry index |
| p_cmd_data | output | 8 | Command entry at `p_cmd_idx` |
| p_rx_we | input | 1 | Peripheral receive write enable |
| p_rx_idx | input | 4 | Receive entry index to write |
| p_rx_data | input | 16 | Received word |
| p_rx_bits | input | 5 | Received word length in bits |
| cptr | output | 4 | Index of the last completed receive entry |

## Verification
The bench builds the block with its default parameters: 16-bit data, 8-bit commands and sixteen entries per segment. With those values the 6-bit pointer covers all four segments, including the unbacked quarter from 0x30 to 0x3F. That coverage makes the wrap from 0x3F to 0x00 reachable, along with the zero returns from the transmit and unbacked regions. The 16-bit word width lets the bench drive bit counts below 8, between 8 and 16, and above 16, so all three branches of the count clamp are exercised.

// File: rtl/qram_pkg.sv
package qram_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_RD_WAIT
    } host_st_t;

    typedef enum logic [1:0] {
        SEG_TX   = 2'd0,
        SEG_RX   = 2'd1,
        SEG_CMD  = 2'd2,
        SEG_VOID = 2'd3
    } seg_t;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_ADDR,
        RSEL_DATA
    } rsel_t;
endpackage

// File: rtl/qram_addr_reg.sv
module qram_addr_reg #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load) begin
            addr_o <= load_val;
        end else if (inc) begin
            addr_o <= addr_o + ADDR_W'(1);   // natural wrap at the top
        end
    end
endmodule

// File: rtl/qram_host_fsm.sv
module qram_host_fsm
    import qram_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel_addr,
    input  logic     sel_data,
    input  logic     rd,
    input  logic     wr,
    output logic     addr_load,
    output logic     addr_inc,
    output logic     mem_we,
    output logic     rd_capture,
    output logic     ready,
    output rsel_t    rsel,
    output host_st_t state_o
);
    host_st_t state_q, state_d;
    logic     data_acc, rd_req;

    assign data_acc = sel_data && !sel_addr;
    assign rd_req   = data_acc && rd && !wr;
    assign state_o  = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        addr_load  = 1'b0;
        addr_inc   = 1'b0;
        mem_we     = 1'b0;
        rd_capture = 1'b0;
        ready      = 1'b1;
        rsel       = RSEL_NONE;
        unique case (state_q)
            ST_IDLE: begin
                addr_load = sel_addr && wr;
                mem_we    = data_acc && wr;
                addr_inc  = data_acc && wr;
                if (sel_addr && rd && !wr) rsel = RSEL_ADDR;
                if (rd_req) begin
                    rd_capture = 1'b1;
                    ready      = 1'b0;
                    state_d    = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                rsel     = RSEL_DATA;
                addr_inc = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/qram_store.sv
module qram_store
    import qram_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CMD_W    = 8,
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 6,
    parameter int MIN_BITS = 8,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int BITS_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [IDX_W-1:0]  p_tx_idx,
    output logic [DATA_W-1:0] p_tx_data,
    input  logic [IDX_W-1:0]  p_cmd_idx,
    output logic [CMD_W-1:0]  p_cmd_data,
    input  logic              p_rx_we,
    input  logic [IDX_W-1:0]  p_rx_idx,
    input  logic [DATA_W-1:0] p_rx_data,
    input  logic [BITS_W-1:0] p_rx_bits,
    output logic [IDX_W-1:0]  cptr_o
);
    logic [DATA_W-1:0] tx_mem  [DEPTH];
    logic [DATA_W-1:0] rx_mem  [DEPTH];
    logic [CMD_W-1:0]  cmd_mem [DEPTH];

    seg_t              seg;
    logic [IDX_W-1:0]  idx;
    logic [BITS_W-1:0] eff_bits;
    logic [DATA_W:0]   one_sh;
    logic [DATA_W-1:0] rx_mask;

    assign seg = seg_t'(h_addr[ADDR_W-1:IDX_W]);
    assign idx = h_addr[IDX_W-1:0];

    // clamp the bit count, then build a mask of that many low ones
    always_comb begin
        if (p_rx_bits < BITS_W'(MIN_BITS))    eff_bits = BITS_W'(MIN_BITS);
        else if (p_rx_bits > BITS_W'(DATA_W)) eff_bits = BITS_W'(DATA_W);
        else                                  eff_bits = p_rx_bits;
        one_sh  = {{DATA_W{1'b0}}, 1'b1} << eff_bits;
        rx_mask = one_sh[DATA_W-1:0] - DATA_W'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_mem[i]  <= '0;
                cmd_mem[i] <= '0;
            end else if (h_we && idx == IDX_W'(i)) begin
                if (seg == SEG_TX)  tx_mem[i]  <= h_wdata;
                if (seg == SEG_CMD) cmd_mem[i] <= h_wdata[CMD_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rx_mem[i] <= '0;
            end else if (p_rx_we && p_rx_idx == IDX_W'(i)) begin
                rx_mem[i] <= p_rx_data & rx_mask;
            end else if (h_we && seg == SEG_RX && idx == IDX_W'(i)) begin
                rx_mem[i] <= h_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cptr_o <= '0;
        else if (p_rx_we) cptr_o <= p_rx_idx;
    end

    always_comb begin
        unique case (seg)
            SEG_RX:  h_rdata = rx_mem[idx];
            SEG_CMD: h_rdata = DATA_W'(cmd_mem[idx]);
            default: h_rdata = '0;
        endcase
    end

    assign p_tx_data  = tx_mem[p_tx_idx];
    assign p_cmd_data = cmd_mem[p_cmd_idx];
endmodule

// File: rtl/qram_ctrl.sv
module qram_ctrl
    import qram_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CMD_W    = 8,
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 6,
    parameter int MIN_BITS = 8,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int BITS_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_sel_addr,
    input  logic              h_sel_data,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_ready,
    input  logic [IDX_W-1:0]  p_tx_idx,
    output logic [DATA_W-1:0] p_tx_data,
    input  logic [IDX_W-1:0]  p_cmd_idx,
    output logic [CMD_W-1:0]  p_cmd_data,
    input  logic              p_rx_we,
    input  logic [IDX_W-1:0]  p_rx_idx,
    input  logic [DATA_W-1:0] p_rx_data,
    input  logic [BITS_W-1:0] p_rx_bits,
    output logic [IDX_W-1:0]  cptr
);
    logic              addr_load, addr_inc, mem_we, rd_capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mem_rdata, rdata_q;
    rsel_t             rsel;
    host_st_t          state_q;

    qram_host_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_addr   (h_sel_addr),
        .sel_data   (h_sel_data),
        .rd         (h_rd),
        .wr         (h_wr),
        .addr_load  (addr_load),
        .addr_inc   (addr_inc),
        .mem_we     (mem_we),
        .rd_capture (rd_capture),
        .ready      (h_ready),
        .rsel       (rsel),
        .state_o    (state_q)
    );

    qram_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val (h_wdata[ADDR_W-1:0]),
        .inc      (addr_inc),
        .addr_o   (addr_q)
    );

    qram_store #(
        .DATA_W   (DATA_W),
        .CMD_W    (CMD_W),
        .DEPTH    (DEPTH),
        .ADDR_W   (ADDR_W),
        .MIN_BITS (MIN_BITS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_we       (mem_we),
        .h_addr     (addr_q),
        .h_wdata    (h_wdata),
        .h_rdata    (mem_rdata),
        .p_tx_idx   (p_tx_idx),
        .p_tx_data  (p_tx_data),
        .p_cmd_idx  (p_cmd_idx),
        .p_cmd_data (p_cmd_data),
        .p_rx_we    (p_rx_we),
        .p_rx_idx   (p_rx_idx),
        .p_rx_data  (p_rx_data),
        .p_rx_bits  (p_rx_bits),
        .cptr_o     (cptr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rdata_q <= '0;
        else if (rd_capture) rdata_q <= mem_rdata;
    end

    always_comb begin
        unique case (rsel)
            RSEL_ADDR: h_rdata = DATA_W'(addr_q);
            RSEL_DATA: h_rdata = rdata_q;
            default:   h_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qram_ctrl_chk.sv
module qram_ctrl_chk
    import qram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_sel_addr,
    input logic              h_sel_data,
    input logic              h_rd,
    input logic              h_wr,
    input logic              h_ready,
    input logic [DATA_W-1:0] h_rdata,
    input logic              p_rx_we,
    input logic [IDX_W-1:0]  p_rx_idx,
    input logic [IDX_W-1:0]  cptr,
    input logic [ADDR_W-1:0] addr_q,
    input host_st_t          state_q
);
    logic rd_req, wr_req;
    logic [ADDR_W-IDX_W-1:0] seg_bits;
    assign rd_req   = state_q == ST_IDLE && h_sel_data && !h_sel_addr && h_rd && !h_wr;
    assign wr_req   = state_q == ST_IDLE && h_sel_data && !h_sel_addr && h_wr;
    assign seg_bits = addr_q[ADDR_W-1:IDX_W];

    // R3
    rd_wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !h_ready);
    // R3
    rd_ready_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> h_ready && state_q == ST_RD_WAIT);
    // R3
    rd_ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RD_WAIT |=> addr_q == $past(addr_q) + ADDR_W'(1));
    // R2
    wr_ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> addr_q == $past(addr_q) + ADDR_W'(1));
    // R5
    tx_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RD_WAIT && seg_bits == '0 |-> h_rdata == '0);
    // R6
    cmd_read_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RD_WAIT && seg_bits == 2'd2 |-> h_rdata[DATA_W-1:CMD_W] == '0);
    // R7
    void_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RD_WAIT && seg_bits == 2'd3 |-> h_rdata == '0);
    // R9
    cptr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_rx_we |=> cptr == $past(p_rx_idx));
endmodule

bind qram_ctrl qram_ctrl_chk #(
    .DATA_W (DATA_W),
    .CMD_W  (CMD_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_sel_addr (h_sel_addr),
    .h_sel_data (h_sel_data),
    .h_rd       (h_rd),
    .h_wr       (h_wr),
    .h_ready    (h_ready),
    .h_rdata    (h_rdata),
    .p_rx_we    (p_rx_we),
    .p_rx_idx   (p_rx_idx),
    .cptr       (cptr),
    .addr_q     (addr_q),
    .state_q    (state_q)
);

// File: tb/test_qram_ctrl.sv
module test_qram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_sel_addr = 0, h_sel_data = 0, h_rd = 0, h_wr = 0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        h_ready;
    logic [3:0]  p_tx_idx = '0, p_cmd_idx = '0, p_rx_idx = '0;
    logic [15:0] p_tx_data;
    logic [7:0]  p_cmd_data;
    logic        p_rx_we = 0;
    logic [15:0] p_rx_data = '0;
    logic [4:0]  p_rx_bits = '0;
    logic [3:0]  cptr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qram_ctrl i_qram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .h_sel_addr(h_sel_addr), .h_sel_data(h_sel_data), .h_rd(h_rd), .h_wr(h_wr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
        .p_tx_idx(p_tx_idx), .p_tx_data(p_tx_data),
        .p_cmd_idx(p_cmd_idx), .p_cmd_data(p_cmd_data),
        .p_rx_we(p_rx_we), .p_rx_idx(p_rx_idx), .p_rx_data(p_rx_data),
        .p_rx_bits(p_rx_bits), .cptr(cptr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_addr(logic [15:0] v);
        @(negedge clk);
        h_sel_addr = 1; h_wr = 1; h_wdata = v;
        @(negedge clk);
        h_sel_addr = 0; h_wr = 0;
    endtask

    task automatic read_addr(output logic [15:0] v);
        @(negedge clk);
        h_sel_addr = 1; h_rd = 1;
        #1;
        v = h_rdata;
        chk("R1 ready on pointer read", h_ready, 1);
        @(negedge clk);
        h_sel_addr = 0; h_rd = 0;
    endtask

    task automatic hwrite(logic [15:0] v);
        @(negedge clk);
        h_sel_data = 1; h_wr = 1; h_wdata = v;
        #1;
        chk("R2 ready during write", h_ready, 1);
        @(negedge clk);
        h_sel_data = 0; h_wr = 0;
    endtask

    task automatic hread(output logic [15:0] v);
        @(negedge clk);
        h_sel_data = 1; h_rd = 1;
        #1;
        chk("R3 wait state", h_ready, 0);
        @(negedge clk);
        chk("R3 ready after wait", h_ready, 1);
        v = h_rdata;
        h_sel_data = 0; h_rd = 0;
    endtask

    task automatic prx(logic [3:0] idx, logic [15:0] d, logic [4:0] bits);
        @(negedge clk);
        p_rx_we = 1; p_rx_idx = idx; p_rx_data = d; p_rx_bits = bits;
        @(negedge clk);
        p_rx_we = 0;
    endtask

    // op: 0 load pointer, 1 data write, 2 data read (check), 3 pointer read (check)
    localparam int NV = 23;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 16'h0000, 16'h0000},
        {2'd1, 16'h1234, 16'h0000},
        {2'd1, 16'hBEEF, 16'h0000},
        {2'd2, 16'h0000, 16'h0000},
        {2'd3, 16'h0000, 16'h0003},
        {2'd0, 16'h0020, 16'h0000},
        {2'd1, 16'hABCD, 16'h0000},
        {2'd0, 16'h0020, 16'h0000},
        {2'd2, 16'h0000, 16'h00CD},
        {2'd3, 16'h0000, 16'h0021},
        {2'd0, 16'h0010, 16'h0000},
        {2'd1, 16'h5A5A, 16'h0000},
        {2'd0, 16'h0010, 16'h0000},
        {2'd2, 16'h0000, 16'h5A5A},
        {2'd0, 16'h0030, 16'h0000},
        {2'd1, 16'hFFFF, 16'h0000},
        {2'd0, 16'h0030, 16'h0000},
        {2'd2, 16'h0000, 16'h0000},
        {2'd0, 16'h003F, 16'h0000},
        {2'd2, 16'h0000, 16'h0000},
        {2'd3, 16'h0000, 16'h0000},
        {2'd0, 16'hFFC5, 16'h0000},
        {2'd3, 16'h0000, 16'h0005}
    };
    localparam string TAG [NV] = '{
        "R1", "R2", "R2", "R5", "R5", "R1", "R6", "R1", "R6", "R6", "R1", "R4",
        "R1", "R4", "R1", "R7", "R1", "R7", "R1", "R7", "R7", "R1", "R1"
    };

    initial begin
        logic [15:0] v;
        // R10: state held in reset
        #1;
        chk("R10 ready in reset", h_ready, 1);
        chk("R10 cptr in reset", cptr, 0);
        chk("R10 tx entry in reset", p_tx_data, 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        read_addr(v);
        chk("R10 pointer after reset", v, 0);

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i][33:32])
                2'd0: set_addr(VEC[i][31:16]);
                2'd1: hwrite(VEC[i][31:16]);
                2'd2: begin hread(v); chk(TAG[i], v, VEC[i][15:0]); end
                default: begin read_addr(v); chk(TAG[i], v, VEC[i][15:0]); end
            endcase
        end

        // R4: peripheral sees transmit words; R7: write at 0x30 did not alias entry 0
        p_tx_idx = 0; #1 chk("R4 tx0 via port (R7 no alias)", p_tx_data, 16'h1234);
        p_tx_idx = 1; #1 chk("R4 tx1 via port", p_tx_data, 16'hBEEF);
        // R6
        p_cmd_idx = 0; #1 chk("R6 cmd0 via port", p_cmd_data, 8'hCD);

        // R8 and R9: masking and clamp
        prx(4'd2, 16'hFFFF, 5'd12);
        chk("R9 cptr after write", cptr, 2);
        prx(4'd5, 16'hABCD, 5'd4);
        chk("R9 cptr after second write", cptr, 5);
        prx(4'd6, 16'h8001, 5'd20);
        set_addr(16'h0012);
        hread(v); chk("R8 mask to 12 bits", v, 16'h0FFF);
        hread(v); chk("R3 burst next entry", v, 16'h0000);
        set_addr(16'h0015);
        hread(v); chk("R8 clamp low to 8", v, 16'h00CD);
        hread(v); chk("R8 clamp high to 16", v, 16'h8001);

        // R11: same-cycle collision on receive entry 7
        set_addr(16'h0017);
        @(negedge clk);
        h_sel_data = 1; h_wr = 1; h_wdata = 16'h1111;
        p_rx_we = 1; p_rx_idx = 4'd7; p_rx_data = 16'h2222; p_rx_bits = 5'd16;
        @(negedge clk);
        h_sel_data = 0; h_wr = 0; p_rx_we = 0;
        set_addr(16'h0017);
        hread(v); chk("R11 peripheral wins", v, 16'h2222);

        // R10: reset mid-run clears contents
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R10 cptr after reset", cptr, 0);
        set_addr(16'h0017);
        hread(v); chk("R10 rx entry cleared", v, 16'h0000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule